// File: doc/BRIEF.md
# Two-by-two programmable logic fabric

This block is a miniature field-programmable fabric. It holds four logic cells in a 2x2 grid and five switch boxes. A serial configuration stream sets the function of every cell and every routing connection. Each cell has a 2-input lookup table and a flip-flop. A per-cell select bit chooses whether the cell drives the lookup result directly or the registered copy of it. Four switch boxes each feed the two inputs of one cell. The fifth switch box picks what reaches the single primary output.

To use it, hold `cfg_en` high and present one configuration bit per clock on `cfg_din`. The stream is 50 bits long and always covers all nine fields, including fields for cells and boxes that the circuit does not use. Once `cfg_en` falls, the fabric computes from the three primary inputs `pin` and drives `pout`. All routing is fixed at configuration time. Each switch-box bit closes one predefined connection, and a cell input with no closed connection reads 0.

Top module: `mini_fabric`

## Requirements
- R1: After reset the configuration store and all cell flip-flops are cleared, so `pout` is 0 for every `pin` value.
- R2: While `cfg_en` is high, one bit of `cfg_din` is taken per rising clock edge. The 50-bit stream carries the fields in the order cell 0, cell 1, cell 2, cell 3, then box 0 to box 4. Within each field the first bit sent is field position 0.
- R3: Positions 0 to 3 of a cell field give the table output for input index {in1,in0} = 0, 1, 2, 3 respectively.
- R4: Position 4 of a cell field set to 1 makes the cell drive the table value captured at the last clock edge with `cfg_en` low. Set to 0, the cell drives the table value directly.
- R5: For cell k (k = 0..3), box k positions 0, 1, 2 connect in0 to `pin[0]`, `pin[2]` and the output of cell k-1. Positions 3, 4, 5 connect in1 to `pin[1]`, `pin[2]` and the output of cell 0. For cell 0 the two cell taps are unconnected.
- R6: Box 4 positions 0 to 5 connect `pout` to `pin[0]`, `pin[1]`, and the outputs of cells 0, 1, 2, 3 respectively.
- R7: When several connections into one node are closed, the node is their OR. When none is closed, the node reads 0.
- R8: While `cfg_en` is high, `pout` is 0 and the cell flip-flops keep their values.
- R9: While `cfg_en` is low, `cfg_din` has no effect on the configuration.
- R10: The configuration sets cell 0 to 00011, box 0 to 100100, cell 3 to 01110, box 3 to 010001 and box 4 to 000001, with all other fields zero. With it, `pout` equals `pin[2]` OR the registered AND of `pin[0]` and `pin[1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_en | input | 1 | High while the configuration stream is shifted in |
| cfg_din | input | 1 | Serial configuration bit |
| pin | input | 3 | Primary inputs |
| pout | output | 1 | Primary output |

## Verification
The table test loads all sixteen truth tables into cell 0 and drives all eight `pin` values. This separates every table entry and its bit position, and shows that `pin[2]` has no effect. The routing tests close one switch bit at a time, for every box position of every cell and for every output tap. The other cells are tied to distinct constants, so a swapped tap or a wrong neighbour shows up as a wrong value. Further patterns close two bits into one node, leave a cell unconnected, and run the registered example through a sequence of inputs. That sequence includes a reload during which the flip-flop would otherwise have captured a different value.

// File: rtl/mini_fabric_pkg.sv
package mini_fabric_pkg;
  localparam int unsigned NCELL  = 4;
  localparam int unsigned NSBOX  = NCELL + 1;
  localparam int unsigned NPIN   = 3;
  localparam int unsigned LUT_IN = 2;
  localparam int unsigned LUT_SZ = 1 << LUT_IN;
  localparam int unsigned CELL_W = LUT_SZ + 1;
  localparam int unsigned SBOX_W = 6;
  localparam int unsigned TAPS   = SBOX_W / LUT_IN;
  localparam int unsigned CFG_W  = NCELL * CELL_W + NSBOX * SBOX_W;
endpackage

// File: rtl/fab_cfg_chain.sv
module fab_cfg_chain #(
  parameter int unsigned W = 50
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] bits
);
  logic [W-1:0] bits_nxt;

  always_comb begin
    bits_nxt = bits;
    if (shift_en) bits_nxt = {bits[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits <= '0;
    else        bits <= bits_nxt;
  end
endmodule

// File: rtl/fab_cell.sv
module fab_cell #(
  parameter int unsigned NIN = 2,
  parameter int unsigned SZ  = 1 << NIN,
  parameter int unsigned FW  = SZ + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [NIN-1:0] in,
  input  logic [FW-1:0]  field,
  output logic           q,
  output logic           ff_q
);
  logic [SZ-1:0] table_v;
  logic          lut_v;
  logic          ff_nxt;

  // field position i (sent i-th) sits at bit FW-1-i
  for (genvar i = 0; i < SZ; i++) begin : g_tt
    assign table_v[i] = field[FW-1-i];
  end

  assign lut_v = table_v[in];

  always_comb begin
    ff_nxt = ff_q;
    if (run) ff_nxt = lut_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= 1'b0;
    else        ff_q <= ff_nxt;
  end

  assign q = field[0] ? ff_q : lut_v;
endmodule

// File: rtl/fab_switch.sv
module fab_switch #(
  parameter int unsigned GROUPS = 2,
  parameter int unsigned TAPS   = 3,
  parameter int unsigned N      = GROUPS * TAPS
) (
  input  logic [N-1:0]      cand,
  input  logic [N-1:0]      sel,
  output logic [GROUPS-1:0] grp
);
  // closed taps are ORed; an open group reads 0
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign grp[g] = |(cand[g*TAPS +: TAPS] & sel[g*TAPS +: TAPS]);
  end
endmodule

// File: rtl/mini_fabric.sv
module mini_fabric
  import mini_fabric_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic            cfg_din,
  input  logic [NPIN-1:0] pin,
  output logic            pout
);
  localparam int unsigned SB_BASE = CFG_W - NCELL * CELL_W;

  logic [1:0]       rst_pipe;
  logic             rst_core_n;
  logic [CFG_W-1:0] cfg_bits;
  logic [NCELL-1:0] cell_q;
  logic [NCELL-1:0] cell_ff;
  logic             run;
  logic [LUT_IN-1:0] out_grp;
  logic [SBOX_W-1:0] out_sel;
  logic [SBOX_W-1:0] out_cand;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];
  assign run        = ~cfg_en;

  fab_cfg_chain #(.W(CFG_W)) u_chain (
    .clk(clk), .rst_n(rst_core_n), .shift_en(cfg_en), .din(cfg_din), .bits(cfg_bits)
  );

  for (genvar k = 0; k < NCELL; k++) begin : g_cell
    logic [SBOX_W-1:0] cand;
    logic [SBOX_W-1:0] sel;
    logic [LUT_IN-1:0] cin;
    logic [CELL_W-1:0] cfield;

    assign cfield = cfg_bits[CFG_W-1-k*CELL_W -: CELL_W];
    for (genvar j = 0; j < SBOX_W; j++) begin : g_sel
      assign sel[j] = cfg_bits[SB_BASE-1-k*SBOX_W-j];
    end

    assign cand[0] = pin[0];
    assign cand[1] = pin[2];
    assign cand[3] = pin[1];
    assign cand[4] = pin[2];
    if (k == 0) begin : g_edge
      assign cand[2] = 1'b0;
      assign cand[5] = 1'b0;
    end else begin : g_inner
      assign cand[2] = cell_q[k-1];
      assign cand[5] = cell_q[0];
    end

    fab_switch #(.GROUPS(LUT_IN), .TAPS(TAPS)) u_sb (
      .cand(cand), .sel(sel), .grp(cin)
    );

    fab_cell #(.NIN(LUT_IN), .SZ(LUT_SZ), .FW(CELL_W)) u_cell (
      .clk(clk), .rst_n(rst_core_n), .run(run), .in(cin), .field(cfield),
      .q(cell_q[k]), .ff_q(cell_ff[k])
    );
  end

  for (genvar j = 0; j < SBOX_W; j++) begin : g_osel
    assign out_sel[j] = cfg_bits[SBOX_W-1-j];
  end
  assign out_cand = {cell_q, pin[1:0]};

  fab_switch #(.GROUPS(LUT_IN), .TAPS(TAPS)) u_sb_out (
    .cand(out_cand), .sel(out_sel), .grp(out_grp)
  );

  assign pout = cfg_en ? 1'b0 : (|out_grp);
endmodule

// File: rtl/mini_fabric_chk.sv
module mini_fabric_chk
  import mini_fabric_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic             cfg_din,
  input logic             pout,
  input logic [CFG_W-1:0] cfg_bits,
  input logic [NCELL-1:0] cell_ff
);
  p_cfg_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (cfg_bits[0] == $past(cfg_din)));

  p_cfg_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg_bits));

  p_ff_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> $stable(cell_ff));

  p_out_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> !pout);

  p_out_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && cfg_bits[SBOX_W-1:0] == '0) |-> !pout);
endmodule

bind mini_fabric mini_fabric_chk u_chk (
  .clk(clk), .rst_n(rst_core_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
  .pout(pout), .cfg_bits(cfg_bits), .cell_ff(cell_ff)
);

// File: tb/mini_fabric_test.sv
module mini_fabric_test;
  logic       clk;
  logic       rst_n;
  logic       cfg_en;
  logic       cfg_din;
  logic [2:0] pin;
  logic       pout;

  int n_chk;
  int n_fail;
  logic [4:0] cf [4];
  logic [5:0] sf [5];

  mini_fabric uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din), .pin(pin), .pout(pout)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pout=%0b expected %0b (pin=%b)", tag, act, exp, pin);
    end
  endtask

  task automatic clear_cfg();
    for (int i = 0; i < 4; i++) cf[i] = 5'b00000;
    for (int i = 0; i < 5; i++) sf[i] = 6'b000000;
  endtask

  task automatic send(input logic [2:0] xload);
    logic [49:0] v;
    v = {cf[0], cf[1], cf[2], cf[3], sf[0], sf[1], sf[2], sf[3], sf[4]};
    for (int i = 49; i >= 0; i--) begin
      @(negedge clk);
      cfg_en  = 1'b1;
      cfg_din = v[i];
      if (i == 49) pin = xload;
      if (i == 25) begin
        #1 chk(pout, 1'b0, "R8 output quiet while loading");
      end
    end
    @(negedge clk);
    cfg_en  = 1'b0;
    cfg_din = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual=hung expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic r;
    logic e;
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    cfg_en = 1'b0;
    cfg_din = 1'b0;
    pin = 3'b000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: cleared after reset
    for (int x = 0; x < 8; x++) begin
      @(negedge clk); pin = 3'(x);
      #1 chk(pout, 1'b0, "R1 reset state");
    end

    // R3: every truth table in cell 0, in0=pin[0], in1=pin[1], out via tap 2
    for (int t = 0; t < 16; t++) begin
      clear_cfg();
      cf[0] = {t[0], t[1], t[2], t[3], 1'b0};
      sf[0] = 6'b100100;
      sf[4] = 6'b001000;
      send(3'b000);
      for (int x = 0; x < 8; x++) begin
        @(negedge clk); pin = 3'(x);
        e = t[{x[1], x[0]}];
        #1 chk(pout, e, "R3 truth table entry");
      end
    end

    // R9: cfg_din toggling with cfg_en low changes nothing (AND table still loaded: t=15 -> const 1; reload AND)
    clear_cfg();
    cf[0] = 5'b00010;
    sf[0] = 6'b100100;
    sf[4] = 6'b001000;
    send(3'b000);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk); cfg_din = c[0];
    end
    @(negedge clk); cfg_din = 1'b0;
    for (int x = 0; x < 4; x++) begin
      @(negedge clk); pin = 3'(x);
      #1 chk(pout, (x == 3), "R9 config kept with cfg_en low");
    end

    // R5: every switch position of every cell box
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 6; j++) begin
        clear_cfg();
        if (k != 0) cf[0] = 5'b11110;
        cf[k] = (j < 3) ? 5'b01010 : 5'b00110;
        sf[k] = 6'b100000 >> j;
        sf[4] = 6'b100000 >> (2 + k);
        send(3'b000);
        for (int x = 0; x < 8; x++) begin
          @(negedge clk); pin = 3'(x);
          case (j)
            0: e = x[0];
            1: e = x[2];
            2: e = (k == 1);
            3: e = x[1];
            4: e = x[2];
            default: e = (k != 0);
          endcase
          #1 chk(pout, e, "R5 cell switch tap");
        end
      end
    end

    // R6: every output tap, cells tied to alternating constants
    for (int p = 0; p < 2; p++) begin
      for (int j = 0; j < 6; j++) begin
        clear_cfg();
        for (int m = 0; m < 4; m++) cf[m] = (((m % 2) ^ p) != 0) ? 5'b11110 : 5'b00000;
        sf[4] = 6'b100000 >> j;
        send(3'b000);
        for (int x = 0; x < 8; x++) begin
          @(negedge clk); pin = 3'(x);
          if (j == 0)      e = x[0];
          else if (j == 1) e = x[1];
          else             e = 1'(((j - 2) % 2) ^ p);
          #1 chk(pout, e, "R6 output tap");
        end
      end
    end

    // R7: OR of two closed taps, and open inputs read 0
    clear_cfg();
    cf[0] = 5'b01010;
    sf[0] = 6'b110000;
    sf[4] = 6'b001000;
    send(3'b000);
    for (int x = 0; x < 8; x++) begin
      @(negedge clk); pin = 3'(x);
      #1 chk(pout, x[0] | x[2], "R7 two taps ORed into cell input");
    end
    clear_cfg();
    cf[0] = 5'b10000;
    sf[4] = 6'b111000;
    send(3'b000);
    for (int x = 0; x < 8; x++) begin
      @(negedge clk); pin = 3'(x);
      #1 chk(pout, 1'b1, "R7 open cell inputs read 0");
    end
    clear_cfg();
    send(3'b000);
    for (int x = 0; x < 8; x++) begin
      @(negedge clk); pin = 3'(x);
      #1 chk(pout, 1'b0, "R7 open output reads 0");
    end

    // R10 / R4: example circuit, pout = pin[2] | reg(pin[0]&pin[1])
    clear_cfg();
    cf[0] = 5'b00011;
    cf[3] = 5'b01110;
    sf[0] = 6'b100100;
    sf[3] = 6'b010001;
    sf[4] = 6'b000001;
    send(3'b000);
    r = 1'b0;
    for (int s = 0; s < 16; s++) begin
      logic [2:0] xv;
      xv = 3'((s * 5 + 3) % 8);
      @(negedge clk); pin = xv;
      #1 chk(pout, xv[2] | r, "R10 example circuit R4 registered cell");
      @(posedge clk);
      r = xv[0] & xv[1];
    end
    @(negedge clk); pin = 3'b011;
    @(posedge clk);
    r = 1'b1;
    // R8: reload while inputs would clear the flop; flop must hold
    send(3'b000);
    #1 chk(pout, r, "R8 flip-flop held during load");
    @(posedge clk);
    #1 chk(pout, 1'b0, "R4 flip-flop updates after load");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule